// File: doc/BRIEF.md
# DDS Phase Generator with Tuning and Offset Register Bank

This block is the digital core of a direct digital synthesizer. Every master clock it advances a 32-bit phase accumulator by a tuning word. From the top of the accumulator it forms a 12-bit phase value that a downstream sine lookup would consume. The output frequency is the tuning word divided by 2^32, times the clock rate. For example, word 0x547AE148 at a 50 MHz clock gives 16.5 MHz.

Two tuning words and four phase offsets are held in a small register bank. A 16-bit parallel write port with a 3-bit address and a write strobe loads them. Each tuning word is loaded as two 16-bit halves. A one-bit frequency select input picks the tuning word used on each clock. A two-bit phase select input picks the offset added to the accumulator's top 12 bits. Toggling these pins gives frequency-shift and phase-shift modulation without disturbing the running phase.

Top module: `dds_phase_core`

## Requirements
- R1: While `wr_en` is high at a rising clock edge, `wr_data` is stored according to `wr_addr`: 000 is tuning word 0 bits 15:0, 001 is tuning word 0 bits 31:16, 010 is tuning word 1 bits 15:0, 011 is tuning word 1 bits 31:16, and 100, 101, 110, 111 are phase offsets 0, 1, 2, 3.
- R2: A half-word write to a tuning word changes only the addressed 16 bits. The other half keeps its value.
- R3: A write to a phase offset stores `wr_data[11:0]`. Bits 15:12 of the data have no effect.
- R4: At each rising edge out of reset, `acc_out` becomes its previous value plus tuning word 0 when `fsel` is 0, or plus tuning word 1 when `fsel` is 1. The word used is the value held before any write on that same edge.
- R5: The accumulator wraps modulo 2^32. After N cycles of a constant word W from zero, `acc_out` equals N·W mod 2^32 and has wrapped floor(N·W / 2^32) times.
- R6: At each rising edge, `phase_out` becomes (previous `acc_out[31:20]` + selected offset) mod 4096. `psel` = 00, 01, 10, 11 selects offset 0, 1, 2, 3. The result has one cycle of latency.
- R7: A change of `fsel` or `psel` takes effect on the next edge and never clears or reloads the accumulator.
- R8: A synchronous active-high `rst` clears the accumulator, `phase_out`, both tuning words and all four offsets to zero. Writes presented during reset are not stored.
- R9: While `wr_en` is low, no tuning word or offset changes, whatever `wr_addr` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | 16 | Write data |
| fsel | input | 1 | Tuning word select |
| psel | input | 2 | Phase offset select |
| acc_out | output | 32 | Phase accumulator value |
| phase_out | output | 12 | Registered offset phase |

## Verification
Two things can happen on the same clock edge: a register write, and the accumulation that reads that register. The bench provokes this by writing a half of the currently selected tuning word, and the currently selected offset, on the very edge that uses them. The result is judged by checking that `acc_out` and `phase_out` advance by the old values on that edge and by the new values only one edge later. Select changes on the same edges as writes are judged the same way: the accumulator must carry on from its value and must not restart.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // Top address bit splits the write space into tuning words and offsets.
    typedef enum logic {
        SPACE_TUNE   = 1'b0,
        SPACE_OFFSET = 1'b1
    } wr_space_e;

endpackage

// File: rtl/dds_wr_decode.sv
module dds_wr_decode #(
    parameter int NUM_FREQ = 2,
    parameter int HALVES   = 2,
    parameter int NUM_OFFS = 4,
    parameter int FIDX_W   = 2,
    parameter int OIDX_W   = 2,
    parameter int ADDR_W   = 3
) (
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    output logic [NUM_FREQ*HALVES-1:0]   half_we,
    output logic [NUM_OFFS-1:0]          offs_we
);
    import dds_pkg::*;

    wr_space_e space;
    assign space = wr_space_e'(wr_addr[ADDR_W-1]);

    // Tuning slot index is {word index, half index}; half index is the LSB.
    for (genvar i = 0; i < NUM_FREQ*HALVES; i++) begin : g_half
        assign half_we[i] = wr_en && (space == SPACE_TUNE)
                            && (wr_addr[FIDX_W-1:0] == FIDX_W'(i));
    end

    for (genvar j = 0; j < NUM_OFFS; j++) begin : g_offs
        assign offs_we[j] = wr_en && (space == SPACE_OFFSET)
                            && (wr_addr[OIDX_W-1:0] == OIDX_W'(j));
    end

endmodule

// File: rtl/dds_tuning_bank.sv
module dds_tuning_bank #(
    parameter int ACC_W    = 32,
    parameter int DATA_W   = 16,
    parameter int NUM_FREQ = 2,
    parameter int FSEL_W   = 1,
    localparam int HALVES  = ACC_W / DATA_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_FREQ*HALVES-1:0]    half_we,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [FSEL_W-1:0]             fsel,
    output logic [NUM_FREQ*ACC_W-1:0]     word_flat,
    output logic [ACC_W-1:0]              word_sel
);
    typedef struct packed {
        logic [NUM_FREQ-1:0][ACC_W-1:0] word;
    } tune_t;

    tune_t tune_d, tune_q;

    always_comb begin
        tune_d = tune_q;
        for (int f = 0; f < NUM_FREQ; f++) begin
            for (int h = 0; h < HALVES; h++) begin
                if (half_we[f*HALVES + h]) begin
                    tune_d.word[f][h*DATA_W +: DATA_W] = wr_data;
                end
            end
        end
        if (rst) begin
            tune_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        tune_q <= tune_d;
    end

    assign word_flat = tune_q.word;
    assign word_sel  = tune_q.word[fsel];

endmodule

// File: rtl/dds_offset_bank.sv
module dds_offset_bank #(
    parameter int PH_W     = 12,
    parameter int DATA_W   = 16,
    parameter int NUM_OFFS = 4,
    parameter int PSEL_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_OFFS-1:0]           offs_we,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [PSEL_W-1:0]             psel,
    output logic [NUM_OFFS*PH_W-1:0]      offs_flat,
    output logic [PH_W-1:0]               offs_sel
);
    typedef struct packed {
        logic [NUM_OFFS-1:0][PH_W-1:0] offs;
    } offs_t;

    offs_t offs_d, offs_q;

    always_comb begin
        offs_d = offs_q;
        for (int k = 0; k < NUM_OFFS; k++) begin
            if (offs_we[k]) begin
                offs_d.offs[k] = wr_data[PH_W-1:0];
            end
        end
        if (rst) begin
            offs_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        offs_q <= offs_d;
    end

    assign offs_flat = offs_q.offs;
    assign offs_sel  = offs_q.offs[psel];

    // Data bits above the offset width are deliberately dropped.
    logic unused_hi;
    assign unused_hi = ^wr_data[DATA_W-1:PH_W];

endmodule

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ACC_W-1:0]  step_word,
    input  logic [PH_W-1:0]   offset,
    output logic [ACC_W-1:0]  acc,
    output logic [PH_W-1:0]   phase
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [PH_W-1:0]  phase;
    } accum_t;

    accum_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.acc   = st_q.acc + step_word;
        st_d.phase = st_q.acc[ACC_W-1 -: PH_W] + offset;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign acc   = st_q.acc;
    assign phase = st_q.phase;

endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core #(
    parameter int ACC_W    = 32,
    parameter int PH_W     = 12,
    parameter int DATA_W   = 16,
    parameter int NUM_FREQ = 2,
    parameter int NUM_OFFS = 4,
    localparam int HALVES  = ACC_W / DATA_W,
    localparam int FSEL_W  = $clog2(NUM_FREQ),
    localparam int PSEL_W  = $clog2(NUM_OFFS),
    localparam int HIDX_W  = $clog2(HALVES),
    localparam int FIDX_W  = FSEL_W + HIDX_W,
    localparam int ADDR_W  = 1 + ((FIDX_W > PSEL_W) ? FIDX_W : PSEL_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [FSEL_W-1:0]  fsel,
    input  logic [PSEL_W-1:0]  psel,
    output logic [ACC_W-1:0]   acc_out,
    output logic [PH_W-1:0]    phase_out
);
    logic [NUM_FREQ*HALVES-1:0] half_we;
    logic [NUM_OFFS-1:0]        offs_we;
    logic [NUM_FREQ*ACC_W-1:0]  freq_flat;
    logic [ACC_W-1:0]           freq_sel;
    logic [NUM_OFFS*PH_W-1:0]   offs_flat;
    logic [PH_W-1:0]            offs_sel;

    dds_wr_decode #(
        .NUM_FREQ (NUM_FREQ),
        .HALVES   (HALVES),
        .NUM_OFFS (NUM_OFFS),
        .FIDX_W   (FIDX_W),
        .OIDX_W   (PSEL_W),
        .ADDR_W   (ADDR_W)
    ) decode_i (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .half_we  (half_we),
        .offs_we  (offs_we)
    );

    dds_tuning_bank #(
        .ACC_W    (ACC_W),
        .DATA_W   (DATA_W),
        .NUM_FREQ (NUM_FREQ),
        .FSEL_W   (FSEL_W)
    ) tune_i (
        .clk       (clk),
        .rst       (rst),
        .half_we   (half_we),
        .wr_data   (wr_data),
        .fsel      (fsel),
        .word_flat (freq_flat),
        .word_sel  (freq_sel)
    );

    dds_offset_bank #(
        .PH_W     (PH_W),
        .DATA_W   (DATA_W),
        .NUM_OFFS (NUM_OFFS),
        .PSEL_W   (PSEL_W)
    ) offs_i (
        .clk       (clk),
        .rst       (rst),
        .offs_we   (offs_we),
        .wr_data   (wr_data),
        .psel      (psel),
        .offs_flat (offs_flat),
        .offs_sel  (offs_sel)
    );

    dds_phase_accum #(
        .ACC_W (ACC_W),
        .PH_W  (PH_W)
    ) accum_i (
        .clk       (clk),
        .rst       (rst),
        .step_word (freq_sel),
        .offset    (offs_sel),
        .acc       (acc_out),
        .phase     (phase_out)
    );

endmodule

// File: rtl/dds_phase_core_chk.sv
module dds_phase_core_chk #(
    parameter int ACC_W    = 32,
    parameter int PH_W     = 12,
    parameter int DATA_W   = 16,
    parameter int NUM_FREQ = 2,
    parameter int NUM_OFFS = 4,
    parameter int FSEL_W   = 1,
    parameter int PSEL_W   = 2,
    parameter int ADDR_W   = 3
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [DATA_W-1:0]             wr_data,
    input logic [FSEL_W-1:0]             fsel,
    input logic [PSEL_W-1:0]             psel,
    input logic [ACC_W-1:0]              acc_out,
    input logic [PH_W-1:0]               phase_out,
    input logic [NUM_FREQ*ACC_W-1:0]     freq_word,
    input logic [NUM_OFFS*PH_W-1:0]      offs_word
);
    logic armed_q = 1'b0;
    logic prev_rst_q = 1'b0;

    always_ff @(posedge clk) begin
        armed_q    <= 1'b1;
        prev_rst_q <= rst;
    end

    // Independent prediction of the next accumulator and phase values.
    logic [ACC_W-1:0] want_acc;
    logic [PH_W-1:0]  want_phase;
    assign want_acc   = acc_out + freq_word[fsel*ACC_W +: ACC_W];
    assign want_phase = acc_out[ACC_W-1 -: PH_W] + offs_word[psel*PH_W +: PH_W];

    p_acc_step_r4: assert property (@(posedge clk) disable iff (rst)
        armed_q |=> acc_out == $past(want_acc));

    p_phase_sum_r6: assert property (@(posedge clk) disable iff (rst)
        armed_q |=> phase_out == $past(want_phase));

    p_half_low_r2: assert property (@(posedge clk) disable iff (rst)
        (armed_q && wr_en && wr_addr == ADDR_W'(0)) |=>
            (freq_word[DATA_W-1:0] == $past(wr_data)) &&
            (freq_word[ACC_W-1:DATA_W] == $past(freq_word[ACC_W-1:DATA_W])));

    p_offs_load_r3: assert property (@(posedge clk) disable iff (rst)
        (armed_q && wr_en && wr_addr[ADDR_W-1]) |=>
            offs_word[$past(wr_addr[PSEL_W-1:0])*PH_W +: PH_W] == $past(wr_data[PH_W-1:0]));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !wr_en) |=>
            $stable(freq_word) && $stable(offs_word));

    // R8: one edge after reset everything reads zero.
    always @(posedge clk) begin
        if (armed_q && prev_rst_q) begin
            p_reset_clear_r8: assert (acc_out == '0 && phase_out == '0 &&
                                      freq_word == '0 && offs_word == '0);
        end
    end

endmodule

bind dds_phase_core dds_phase_core_chk #(
    .ACC_W    (ACC_W),
    .PH_W     (PH_W),
    .DATA_W   (DATA_W),
    .NUM_FREQ (NUM_FREQ),
    .NUM_OFFS (NUM_OFFS),
    .FSEL_W   (FSEL_W),
    .PSEL_W   (PSEL_W),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .fsel      (fsel),
    .psel      (psel),
    .acc_out   (acc_out),
    .phase_out (phase_out),
    .freq_word (freq_flat),
    .offs_word (offs_flat)
);

// File: tb/dds_phase_core_tb_top.sv
module dds_phase_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_LEN    = 1000;
    localparam logic [31:0] WORD_16M5 = 32'h547AE148;

    logic        clk = 1'b0;
    logic        rst, wr_en, fsel;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [1:0]  psel;
    logic [31:0] acc_out;
    logic [11:0] phase_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    dds_phase_core dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fsel(fsel), .psel(psel),
        .acc_out(acc_out), .phase_out(phase_out)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [31:0] ref_acc;
    logic [11:0] ref_out;
    logic [31:0] ref_freq [0:1];
    logic [11:0] ref_offs [0:3];

    // Vector fields: {wr_en, addr[2:0], data[15:0], fsel, psel[1:0]}
    localparam logic [22:0] VEC [0:15] = '{
        {1'b1, 3'd0, 16'h1234, 1'b0, 2'd0},   // R1 word0 low
        {1'b1, 3'd1, 16'h0001, 1'b0, 2'd0},   // R1/R4 word0 high, same-edge use
        {1'b1, 3'd2, 16'h8000, 1'b1, 2'd1},   // R1 word1 low
        {1'b1, 3'd3, 16'h4000, 1'b1, 2'd1},   // R1 word1 high
        {1'b1, 3'd4, 16'hF0A5, 1'b0, 2'd0},   // R3 upper bits dropped
        {1'b1, 3'd5, 16'h0FFF, 1'b0, 2'd1},   // R6 offset 1 same-edge
        {1'b1, 3'd6, 16'h0800, 1'b1, 2'd2},
        {1'b1, 3'd7, 16'h0123, 1'b1, 2'd3},
        {1'b0, 3'd1, 16'hFFFF, 1'b0, 2'd0},   // R9 idle bus
        {1'b0, 3'd6, 16'hFFFF, 1'b1, 2'd1},
        {1'b0, 3'd2, 16'hAAAA, 1'b0, 2'd2},
        {1'b0, 3'd7, 16'h5555, 1'b1, 2'd3},
        {1'b1, 3'd0, 16'hFFFF, 1'b0, 2'd0},   // R2/R4 low half only
        {1'b1, 3'd3, 16'hFFFF, 1'b1, 2'd2},
        {1'b0, 3'd0, 16'h0000, 1'b1, 2'd3},   // R7 select swaps
        {1'b0, 3'd0, 16'h0000, 1'b0, 2'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input bit r, input bit we, input logic [2:0] a,
                        input logic [15:0] d, input bit fs, input logic [1:0] ps);
        rst = r; wr_en = we; wr_addr = a; wr_data = d; fsel = fs; psel = ps;
        if (r) begin
            ref_acc = '0; ref_out = '0;
            for (int i = 0; i < 2; i++) ref_freq[i] = '0;
            for (int i = 0; i < 4; i++) ref_offs[i] = '0;
        end else begin
            ref_out = 12'(ref_acc[31:20] + ref_offs[ps]);
            ref_acc = ref_acc + ref_freq[fs];
            if (we) begin
                if (!a[2]) begin
                    if (a[0]) ref_freq[a[1]][31:16] = d;
                    else      ref_freq[a[1]][15:0]  = d;
                end else begin
                    ref_offs[a[1:0]] = d[11:0];
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input bit fs, input logic [1:0] ps);
        step(1'b0, 1'b0, 3'd0, 16'h0000, fs, ps);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1..all actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] prev;
        logic [63:0] prod;
        int wraps;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; fsel = 1'b0; psel = '0;
        @(negedge clk);
        step(1'b1, 1'b0, 3'd0, 16'h0, 1'b0, 2'd0);
        step(1'b1, 1'b0, 3'd0, 16'h0, 1'b0, 2'd0);
        chk("R8 reset acc", acc_out, 32'h0);
        chk("R8 reset phase", 32'(phase_out), 32'h0);

        // Table walk against the reference model
        for (int i = 0; i < 16; i++) begin
            logic [22:0] v;
            v = VEC[i];
            step(1'b0, v[22], v[21:19], v[18:3], v[2], v[1:0]);
            chk("R1/R2/R4/R5 table acc", acc_out, ref_acc);
            chk("R3/R6/R7/R9 table phase", 32'(phase_out), 32'(ref_out));
        end

        // R8: write during reset is not stored
        step(1'b1, 1'b1, 3'd4, 16'h0555, 1'b0, 2'd0);
        idle(1'b0, 2'd0);
        idle(1'b0, 2'd0);
        chk("R8 write in reset dropped", 32'(phase_out), 32'h0);
        chk("R8 acc held at zero", acc_out, 32'h0);

        // R3: upper data bits ignored, observed with acc at zero
        step(1'b0, 1'b1, 3'd5, 16'hFABC, 1'b0, 2'd1);
        idle(1'b0, 2'd1);
        chk("R3 offset low 12 bits", 32'(phase_out), 32'h0ABC);

        // R5: 16.5 MHz word over many cycles
        step(1'b1, 1'b0, 3'd0, 16'h0, 1'b0, 2'd0);
        step(1'b0, 1'b1, 3'd0, WORD_16M5[15:0], 1'b1, 2'd0);
        step(1'b0, 1'b1, 3'd1, WORD_16M5[31:16], 1'b1, 2'd0);
        chk("R4 unselected word not added", acc_out, 32'h0);
        wraps = 0;
        for (int n = 0; n < RUN_LEN; n++) begin
            prev = acc_out;
            idle(1'b0, 2'd0);
            if (acc_out < prev) wraps++;
        end
        prod = 64'(RUN_LEN) * 64'(WORD_16M5);
        chk("R5 acc after run", acc_out, prod[31:0]);
        chk("R5 wrap count", 32'(wraps), prod[63:32]);
        chk("R6 phase after run", 32'(phase_out), 32'(ref_out));

        // R6: phase sum wraps modulo 4096
        step(1'b1, 1'b0, 3'd0, 16'h0, 1'b0, 2'd0);
        step(1'b0, 1'b1, 3'd0, 16'h0000, 1'b1, 2'd3);
        step(1'b0, 1'b1, 3'd1, 16'hFFF0, 1'b1, 2'd3);
        step(1'b0, 1'b1, 3'd7, 16'h0002, 1'b1, 2'd3);
        idle(1'b0, 2'd3);
        chk("R4 acc one step", acc_out, 32'hFFF00000);
        chk("R6 phase pre-wrap", 32'(phase_out), 32'h002);
        idle(1'b1, 2'd3);
        chk("R6 phase modulo 4096", 32'(phase_out), 32'h001);
        chk("R7 acc kept on fsel change", acc_out, 32'hFFF00000);
        idle(1'b0, 2'd0);
        chk("R5 acc wraps modulo 2^32", acc_out, 32'hFFE00000);
        chk("R7 psel change next edge", 32'(phase_out), 32'hFFF);

        // R4: same-edge write to the selected word uses the old value
        step(1'b0, 1'b1, 3'd1, 16'h0000, 1'b0, 2'd0);
        chk("R4 old word on write edge", acc_out, 32'hFFD00000);
        idle(1'b0, 2'd0);
        chk("R2/R4 new word after write", acc_out, 32'hFFD00000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule